// File: doc/BRIEF.md
# Sample Clock Sequencer with Strobe

This block sets the pace of a data acquisition unit. While running, it raises a one-cycle sample event on each tick of an internal interval timer. When both the period field and the source selector are zero, the event comes instead from a falling edge on an external active-low clock input. The other acquisition channels use the event pulse to take their samples.

On every event the block captures the next digital output word into its output register. It also pulls an active-low clock-out strobe low for a fixed number of system cycles. The output word changes on the same edge that the strobe falls, so it is settled well before the strobe rises. The strobe can feed the external clock input of a further unit, which then runs as a slave.

When the internal period is below a fast-rate limit, the strobe is left out. The events and the output updates still happen.

Top module: `smpclk_seq`

## Requirements
- R1: After reset the strobe `clk_out_n` is high, `dout` is zero, `sample_evt` is low, and the block is stopped, so no events occur until a start command.
- R2: Events occur only while running. A start and a stop in the same cycle leave the block stopped. The cycle after a stop command shows `clk_out_n` high and no event, even if a strobe was in progress.
- R3: In timer mode, with period value P, events are max(P,1) cycles apart. The first event appears max(P,1)−1 cycles after the clock edge that registers the start command.
- R4: The external clock input is the event source only when `cfg_period` is 0 and `cfg_src` is 0. With any other setting, edges on it have no effect on the events.
- R5: In external mode, each high-to-low transition of `ext_clk_n` produces exactly one one-cycle `sample_evt`, however long the input stays low. The input passes through a two-flop synchroniser first.
- R6: Each strobed event drives `clk_out_n` low for STROBE_CYC cycles, starting at the clock edge after the event. `clk_out_n` never falls without an event in the preceding cycle.
- R7: `dout` loads `dout_next` at the clock edge after each event, the same edge at which the strobe falls. `dout` holds its value in every other cycle.
- R8: In timer mode with `cfg_period` below FAST_LIMIT, the strobe is suppressed and `clk_out_n` stays high. Events and `dout` updates continue as usual.
- R9: An event that arrives while the strobe is low is still accepted (event pulse and `dout` update), but it neither restarts nor lengthens the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | PERIOD_W | Sample period in system clock cycles |
| cfg_src | input | SRC_W | Clock-source selector; external clock needs zero here and in the period |
| run_start | input | 1 | One-cycle start command |
| run_stop | input | 1 | One-cycle stop command; wins over start |
| ext_clk_n | input | 1 | Asynchronous active-low external sample clock |
| dout_next | input | OUT_W | Value to present on the digital outputs at the next event |
| dout | output | OUT_W | Registered digital output port |
| clk_out_n | output | 1 | Active-low sample strobe |
| sample_evt | output | 1 | One-cycle pulse per sample event for the other channels |

## Verification
The checker watches several rules on every cycle:
- the event pulse stays low while stopped, using its own run-state tracker;
- a stop command leaves a quiet cycle after it;
- the strobe only falls after an event and never stays low longer than STROBE_CYC;
- `dout` holds between events;
- in fast timer settings the strobe stays high.

Only the directed scenarios can show the rest:
- the exact event spacing and the start-to-first-event latency;
- one event per external pulse, and external edges being ignored outside external mode;
- the merged strobe when two events overlap;
- that captured output words match the values supplied.

// File: rtl/smpclk_pkg.sv
package smpclk_pkg;

   // Origin of the sample event currently in force
   typedef enum logic {
      SRC_TIMER = 1'b0,
      SRC_EXT   = 1'b1
   } smp_src_e;

   // Timer reload value: a period of zero behaves like a period of one
   function automatic logic [31:0] reload_of(input logic [31:0] period);
      return (period == 32'd0) ? 32'd0 : period - 32'd1;
   endfunction

endpackage

// File: rtl/smpclk_edge_sync.sv
module smpclk_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_n,
   output logic fall
);
   localparam int MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("smpclk_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [MSB:0] sync_q;
   logic         prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[MSB-1:0], din_n};
         prev_q <= sync_q[MSB];
      end
   end

   assign fall = prev_q & ~sync_q[MSB];
endmodule

// File: rtl/smpclk_interval_timer.sv
module smpclk_interval_timer #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [PERIOD_W-1:0] period,
   output logic                tick
);
   import smpclk_pkg::*;

   logic [PERIOD_W-1:0] cnt_q;
   logic [PERIOD_W-1:0] reload;

   assign reload = PERIOD_W'(reload_of(32'(period)));
   assign tick   = enable && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!enable || tick)
         cnt_q <= reload;
      else
         cnt_q <= cnt_q - PERIOD_W'(1);
   end
endmodule

// File: rtl/smpclk_strobe_gen.sv
module smpclk_strobe_gen #(
   parameter int STROBE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt,
   input  logic evt,
   input  logic strobe_en,
   output logic strobe_n
);
   localparam int CNT_W = $clog2(STROBE_CYC + 1);

   if (STROBE_CYC < 1) begin : g_bad_width
      $error("smpclk_strobe_gen: STROBE_CYC must be at least 1");
   end

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_q <= '0;
      else if (halt)
         left_q <= '0;
      else if (left_q != '0)
         left_q <= left_q - CNT_W'(1);
      else if (evt && strobe_en)
         left_q <= CNT_W'(STROBE_CYC);
   end

   assign strobe_n = (left_q == '0);
endmodule

// File: rtl/smpclk_seq.sv
module smpclk_seq #(
   parameter int PERIOD_W      = 16,
   parameter int SRC_W         = 2,
   parameter int OUT_W         = 8,
   parameter int STROBE_CYC    = 4,
   parameter int FAST_LIMIT    = 40,
   parameter int SYNC_STAGES   = 2,
   parameter bit SUPPRESS_FAST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] cfg_period,
   input  logic [SRC_W-1:0]    cfg_src,
   input  logic                run_start,
   input  logic                run_stop,
   input  logic                ext_clk_n,
   input  logic [OUT_W-1:0]    dout_next,
   output logic [OUT_W-1:0]    dout,
   output logic                clk_out_n,
   output logic                sample_evt
);
   import smpclk_pkg::*;

   if (FAST_LIMIT < 0 || FAST_LIMIT >= (1 << PERIOD_W)) begin : g_bad_limit
      $error("smpclk_seq: FAST_LIMIT must fit in PERIOD_W bits");
   end
   if (OUT_W < 1 || SRC_W < 1) begin : g_bad_width
      $error("smpclk_seq: OUT_W and SRC_W must be positive");
   end

   smp_src_e src_sel;
   logic     running_q;
   logic     active;
   logic     ext_fall;
   logic     tmr_tick;
   logic     strobe_en;

   assign src_sel = (cfg_period == '0 && cfg_src == '0) ? SRC_EXT : SRC_TIMER;
   assign active  = running_q && !run_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         running_q <= 1'b0;
      else if (run_stop)
         running_q <= 1'b0;
      else if (run_start)
         running_q <= 1'b1;
   end

   smpclk_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din_n (ext_clk_n),
      .fall  (ext_fall)
   );

   smpclk_interval_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (active && src_sel == SRC_TIMER),
      .period (cfg_period),
      .tick   (tmr_tick)
   );

   assign sample_evt = active &&
                       ((src_sel == SRC_EXT) ? ext_fall : tmr_tick);

   if (SUPPRESS_FAST) begin : g_suppress
      assign strobe_en = (src_sel == SRC_EXT) ||
                         (cfg_period >= PERIOD_W'(FAST_LIMIT));
   end else begin : g_always
      assign strobe_en = 1'b1;
   end

   smpclk_strobe_gen #(.STROBE_CYC(STROBE_CYC)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt      (run_stop),
      .evt       (sample_evt),
      .strobe_en (strobe_en),
      .strobe_n  (clk_out_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout <= '0;
      else if (sample_evt)
         dout <= dout_next;
   end
endmodule

// File: rtl/smpclk_seq_chk.sv
module smpclk_seq_chk #(
   parameter int PERIOD_W      = 16,
   parameter int SRC_W         = 2,
   parameter int OUT_W         = 8,
   parameter int STROBE_CYC    = 4,
   parameter int FAST_LIMIT    = 40,
   parameter bit SUPPRESS_FAST = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [PERIOD_W-1:0] cfg_period,
   input logic [SRC_W-1:0]    cfg_src,
   input logic                run_start,
   input logic                run_stop,
   input logic [OUT_W-1:0]    dout,
   input logic                clk_out_n,
   input logic                sample_evt
);
   localparam int LOW_W = $clog2(STROBE_CYC + 2);

   logic             run_seen_q;
   logic [LOW_W-1:0] low_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_seen_q <= 1'b0;
         low_run_q  <= '0;
      end else begin
         run_seen_q <= run_stop ? 1'b0 : (run_start ? 1'b1 : run_seen_q);
         if (clk_out_n)
            low_run_q <= '0;
         else if (low_run_q <= LOW_W'(STROBE_CYC))
            low_run_q <= low_run_q + LOW_W'(1);
      end
   end

   // R1 / R2: no events while stopped
   p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_seen_q |-> !sample_evt);

   p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_stop |=> (clk_out_n && !sample_evt));

   p_strobe_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_out_n) |-> $past(sample_evt));

   p_strobe_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      low_run_q <= LOW_W'(STROBE_CYC));

   p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_evt |=> $stable(dout));

   if (SUPPRESS_FAST) begin : g_fast_chk
      p_fast_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ((cfg_period != '0 || cfg_src != '0) &&
          cfg_period < PERIOD_W'(FAST_LIMIT) && clk_out_n) |=> clk_out_n);
   end
endmodule

bind smpclk_seq smpclk_seq_chk #(
   .PERIOD_W      (PERIOD_W),
   .SRC_W         (SRC_W),
   .OUT_W         (OUT_W),
   .STROBE_CYC    (STROBE_CYC),
   .FAST_LIMIT    (FAST_LIMIT),
   .SUPPRESS_FAST (SUPPRESS_FAST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_period (cfg_period),
   .cfg_src    (cfg_src),
   .run_start  (run_start),
   .run_stop   (run_stop),
   .dout       (dout),
   .clk_out_n  (clk_out_n),
   .sample_evt (sample_evt)
);

// File: tb/smpclk_seq_tb.sv
`timescale 1ns/1ps
module smpclk_seq_tb_top;
   localparam int PERIOD_W   = 16;
   localparam int SRC_W      = 2;
   localparam int OUT_W      = 8;
   localparam int STROBE_CYC = 4;
   localparam int FAST_LIMIT = 40;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [PERIOD_W-1:0] cfg_period = '0;
   logic [SRC_W-1:0]    cfg_src = '0;
   logic                run_start = 1'b0;
   logic                run_stop = 1'b0;
   logic                ext_clk_n = 1'b1;
   logic [OUT_W-1:0]    dout_next = '0;
   logic [OUT_W-1:0]    dout;
   logic                clk_out_n;
   logic                sample_evt;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   smpclk_seq #(
      .PERIOD_W(PERIOD_W), .SRC_W(SRC_W), .OUT_W(OUT_W),
      .STROBE_CYC(STROBE_CYC), .FAST_LIMIT(FAST_LIMIT),
      .SYNC_STAGES(2), .SUPPRESS_FAST(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_src(cfg_src),
      .run_start(run_start), .run_stop(run_stop), .ext_clk_n(ext_clk_n),
      .dout_next(dout_next), .dout(dout), .clk_out_n(clk_out_n),
      .sample_evt(sample_evt)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_start();
      run_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      run_start = 1'b0;
   endtask

   task automatic do_stop();
      run_stop = 1'b1;
      @(posedge clk);
      @(negedge clk);
      run_stop = 1'b0;
   endtask

   task automatic watch(input int cyc, output int evts, output int lows);
      evts = 0;
      lows = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (sample_evt) evts++;
         if (!clk_out_n) lows++;
      end
   endtask

   task automatic t_reset();
      int e, l;
      check(clk_out_n == 1'b1, "R1 strobe idle", clk_out_n, 1);
      check(dout == '0, "R1 dout reset", dout, 0);
      check(sample_evt == 1'b0, "R1 no event", sample_evt, 0);
      cfg_period = 16'd5;
      cfg_src    = 2'd1;
      watch(20, e, l);
      check(e == 0, "R1 R2 no events before start", e, 0);
   endtask

   task automatic t_internal();
      int n, m;
      cfg_period = 16'd50;
      cfg_src    = 2'd1;
      dout_next  = 8'hA5;
      do_start();
      n = 0;
      while (!sample_evt && n < 1000) begin
         @(negedge clk);
         n++;
      end
      check(n == 49, "R3 first event latency", n, 49);
      @(negedge clk);
      check(dout == 8'hA5, "R7 dout captured", dout, 8'hA5);
      check(clk_out_n == 1'b0, "R6 strobe low after event", clk_out_n, 0);
      m = 1;
      while (!sample_evt && m < 1000) begin
         @(negedge clk);
         m++;
      end
      check(m == 50, "R3 event spacing", m, 50);
      do_stop();
   endtask

   task automatic t_external();
      int e1, l1, e2, l2;
      cfg_period = '0;
      cfg_src    = '0;
      dout_next  = 8'h3C;
      do_start();
      watch(5, e1, l1);
      check(e1 == 0, "R5 no event without edge", e1, 0);
      ext_clk_n = 1'b0;
      watch(3, e1, l1);
      ext_clk_n = 1'b1;
      watch(15, e2, l2);
      check(e1 + e2 == 1, "R5 one event per falling edge", e1 + e2, 1);
      check(l1 + l2 == STROBE_CYC, "R6 strobe width", l1 + l2, STROBE_CYC);
      check(dout == 8'h3C, "R7 dout after external event", dout, 8'h3C);
      do_stop();
   endtask

   task automatic t_overlap();
      int e1, l1, e2, l2, e3, l3, e4, l4;
      cfg_period = '0;
      cfg_src    = '0;
      do_start();
      ext_clk_n = 1'b0; watch(1, e1, l1);
      ext_clk_n = 1'b1; watch(1, e2, l2);
      ext_clk_n = 1'b0; watch(1, e3, l3);
      ext_clk_n = 1'b1; watch(15, e4, l4);
      check(e1 + e2 + e3 + e4 == 2, "R9 both events accepted", e1 + e2 + e3 + e4, 2);
      check(l1 + l2 + l3 + l4 == STROBE_CYC, "R9 strobe not restarted",
            l1 + l2 + l3 + l4, STROBE_CYC);
      do_stop();
   endtask

   task automatic t_ext_ignored();
      int e1, l1, e2, l2;
      cfg_period = 16'd200;
      cfg_src    = '0;
      do_start();
      ext_clk_n = 1'b0; watch(3, e1, l1);
      ext_clk_n = 1'b1; watch(20, e2, l2);
      check(e1 + e2 == 0, "R4 ext ignored with nonzero period", e1 + e2, 0);
      do_stop();
      cfg_period = '0;
      cfg_src    = 2'd2;
      do_start();
      watch(2, e1, l1);
      ext_clk_n = 1'b0; watch(4, e1, l1);
      ext_clk_n = 1'b1; watch(6, e2, l2);
      check(e1 + e2 == 10, "R4 R3 period zero timer runs every cycle", e1 + e2, 10);
      check(l1 + l2 == 0, "R8 no strobe at period zero in timer mode", l1 + l2, 0);
      do_stop();
   endtask

   task automatic t_fast();
      int e, l;
      cfg_period = 16'd10;
      cfg_src    = 2'd1;
      dout_next  = 8'h5A;
      do_start();
      watch(40, e, l);
      check(e == 4, "R8 events continue when fast", e, 4);
      check(l == 0, "R8 strobe suppressed", l, 0);
      check(dout == 8'h5A, "R8 R7 dout still updated", dout, 8'h5A);
      do_stop();
   endtask

   task automatic t_stop();
      int e, l, n;
      cfg_period = '0;
      cfg_src    = '0;
      do_start();
      ext_clk_n = 1'b0;
      n = 0;
      while (clk_out_n && n < 20) begin
         @(negedge clk);
         n++;
      end
      ext_clk_n = 1'b1;
      check(clk_out_n == 1'b0, "R6 strobe started", clk_out_n, 0);
      do_stop();
      check(clk_out_n == 1'b1, "R2 stop forces strobe high", clk_out_n, 1);
      ext_clk_n = 1'b0; watch(3, e, l);
      ext_clk_n = 1'b1; watch(8, e, l);
      check(e == 0 && l == 0, "R2 no events after stop", e + l, 0);
      run_start = 1'b1;
      run_stop  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      run_start = 1'b0;
      run_stop  = 1'b0;
      ext_clk_n = 1'b0; watch(3, e, l);
      ext_clk_n = 1'b1; watch(8, e, l);
      check(e == 0, "R2 stop wins over start", e, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_internal();
      t_external();
      t_overlap();
      t_ext_ignored();
      t_fast();
      t_stop();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule